// File: doc/BRIEF.md
# Late-Write SRAM with Pending-Write Forwarding

This block is an on-chip synchronous memory for bus masters that switch between reads and writes on every cycle. A write gives its address and byte enables in one cycle and its data a fixed number of cycles later. The number is one for the flow-through build and two for the pipelined build. A read returns its word after the same number of cycles. Because both kinds of access use the same delay, the data bus is never contested and no idle cycle is needed when the direction changes.

While a write waits for its data, the block keeps its address and lane mask in a short shift register. It writes the word into the array in the cycle the data arrives. A read that overlaps such a pending write sees the new bytes. Those bytes come from the data input as it arrives, lane by lane, and the youngest write to a lane wins. A cycle with the chip deselected moves the pipeline along but neither queues a write nor produces read data.

Top module: `zt_sram`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `dvalid` is 0 and no array write takes place.
- R2: A read issued at a clock edge (`ce`=1, `we`=0) makes `dvalid` 1 with the word on `dout` exactly L cycles later. L is 2 when `PIPELINED`=1 and 1 when `PIPELINED`=0. `dvalid` is 0 in every other cycle.
- R3: A write issued at a clock edge (`ce`=1, `we`=1) takes `addr` and `ben` at that edge and takes its data from `din` at the edge L cycles later, when it is stored in the array.
- R4: Any mix of reads, writes and deselects issued on consecutive cycles returns, for every read, the contents written by all earlier-issued writes, with no wait cycle.
- R5: A read whose address matches a write issued 1 to L cycles earlier returns that write's data, not the old array contents.
- R6: When two pending writes target a read's address, each enabled lane returns the younger write's byte.
- R7: Forwarding works per lane. Lane i is bits [8i+7:8i]. A lane not enabled in a pending write returns the byte from an older pending write or from the array.
- R8: A cycle with `ce`=0 produces no `dvalid` L cycles later and does not change the array, whatever `we`, `addr` and `ben` are.
- R9: A write changes only the lanes whose `ben` bit is 1. Other lanes keep their stored bytes.
- R10: `din` is ignored in cycles that are not the data cycle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable; 0 makes the cycle a deselect |
| we | input | 1 | 1 for write, 0 for read, when `ce` is 1 |
| addr | input | ADDR_W | Word address of the access |
| ben | input | DATA_W/8 | Byte enables of a write, given with the address |
| din | input | DATA_W | Write data, L cycles after the write address |
| dout | output | DATA_W | Read data |
| dvalid | output | 1 | `dout` holds a read result |

## Verification
A scoreboard keeps an ordered memory model. Each read expects the model word at its issue time, due exactly L cycles later. Plain runs of writes followed by reads test the array path and the latency alone. Reads placed zero, one and two cycles behind a write to the same address separate forwarding from the input register from forwarding at the commit edge. Paired writes to one address, with full and partial lane masks, separate youngest-wins from lane-wise merging. Deselect cycles that carry a write strobe, garbage on `din`, and a long random mix show whether anything outside a real data cycle leaks into the array or the output.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  // Kind of access presented at the address edge.
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } zt_op_e;

  // Cycles between an address edge and its data edge.
  function automatic int unsigned zt_latency(input bit pipelined);
    return pipelined ? 2 : 1;
  endfunction

endpackage

// File: rtl/zt_sram_bank.sv
// Byte-laned storage: one simple dual-port RAM per lane, read-first,
// registered read port, so each lane maps onto a block RAM.
module zt_sram_bank #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [LANES-1:0]          wr_lanes,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANES*LANE_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [LANES*LANE_W-1:0]   rd_data
);
  localparam int WORDS = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [WORDS];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_lanes[l]) begin
        mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
      end
      q <= mem[rd_addr];
    end

    assign rd_data[l*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/zt_sram_wrq.sv
// Pending-write tracker: address and lane mask of each write travel down
// DEPTH stages; the last stage is the write whose data is on the bus now.
module zt_sram_wrq #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [LANES-1:0]  push_lanes,
  output logic              com_vld,
  output logic [ADDR_W-1:0] com_addr,
  output logic [LANES-1:0]  com_lanes
);
  logic [DEPTH-1:0]             vld;
  logic [DEPTH-1:0][ADDR_W-1:0] adr;
  logic [DEPTH-1:0][LANES-1:0]  lns;

  always_ff @(posedge clk) begin
    adr[0] <= push_addr;
    lns[0] <= push_lanes;
    for (int s = 1; s < DEPTH; s++) begin
      adr[s] <= adr[s-1];
      lns[s] <= lns[s-1];
    end
    if (rst) begin
      vld <= '0;
    end else begin
      vld[0] <= push;
      for (int s = 1; s < DEPTH; s++) begin
        vld[s] <= vld[s-1];
      end
    end
  end

  assign com_vld   = vld[DEPTH-1];
  assign com_addr  = adr[DEPTH-1];
  assign com_lanes = lns[DEPTH-1];

endmodule

// File: rtl/zt_sram_rdp.sv
// Read path: tracks in-flight reads, grabs bytes of any write that commits
// while a read is still in flight, and merges them over the array word.
module zt_sram_rdp #(
  parameter int ADDR_W    = 8,
  parameter int LANE_W    = 8,
  parameter int LANES     = 4,
  parameter bit PIPELINED = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_go,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    com_vld,
  input  logic [ADDR_W-1:0]       com_addr,
  input  logic [LANES-1:0]        com_lanes,
  input  logic [LANES*LANE_W-1:0] com_data,
  input  logic [LANES*LANE_W-1:0] arr_q,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dvalid
);
  localparam int DATA_W = LANES * LANE_W;

  // The write committing now is older than the read issued now: the array
  // read at this edge sees old bytes, so take them from the data input.
  logic [LANES-1:0] fwd0_mask;
  assign fwd0_mask = (rd_go && com_vld && (com_addr == rd_addr)) ? com_lanes : '0;

  logic              s1_vld;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_mask;
  logic [DATA_W-1:0] s1_data;

  always_ff @(posedge clk) begin
    s1_addr <= rd_addr;
    s1_mask <= fwd0_mask;
    s1_data <= com_data;
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= rd_go;
  end

  if (PIPELINED) begin : g_pipe
    // One cycle later the next-older write commits; it overrides s1 bytes.
    logic              hit1;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] dout_r;
    logic              dvalid_r;

    assign hit1 = s1_vld && com_vld && (com_addr == s1_addr);

    always_comb begin
      for (int l = 0; l < LANES; l++) begin
        if (hit1 && com_lanes[l])
          merged[l*LANE_W +: LANE_W] = com_data[l*LANE_W +: LANE_W];
        else if (s1_mask[l])
          merged[l*LANE_W +: LANE_W] = s1_data[l*LANE_W +: LANE_W];
        else
          merged[l*LANE_W +: LANE_W] = arr_q[l*LANE_W +: LANE_W];
      end
    end

    always_ff @(posedge clk) begin
      dout_r <= merged;
      if (rst) dvalid_r <= 1'b0;
      else     dvalid_r <= s1_vld;
    end

    assign dout   = dout_r;
    assign dvalid = dvalid_r;
  end else begin : g_flow
    logic [DATA_W-1:0] merged;
    logic [ADDR_W-1:0] unused_addr;

    assign unused_addr = s1_addr;

    always_comb begin
      for (int l = 0; l < LANES; l++) begin
        merged[l*LANE_W +: LANE_W] = s1_mask[l] ? s1_data[l*LANE_W +: LANE_W]
                                                : arr_q[l*LANE_W +: LANE_W];
      end
    end

    assign dout   = merged;
    assign dvalid = s1_vld;
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter bit PIPELINED = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ce,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W/8-1:0]    ben,
  input  logic [DATA_W-1:0]      din,
  output logic [DATA_W-1:0]      dout,
  output logic                   dvalid
);
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;
  localparam int LAT    = zt_latency(PIPELINED);

  zt_op_e op;
  assign op = !ce ? OP_NONE : (we ? OP_WRITE : OP_READ);

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [LANES-1:0]  mem_wbe;
  logic [DATA_W-1:0] arr_q;

  zt_sram_wrq #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .DEPTH  (LAT)
  ) u_wrq (
    .clk        (clk),
    .rst        (rst),
    .push       (op == OP_WRITE),
    .push_addr  (addr),
    .push_lanes (ben),
    .com_vld    (mem_we),
    .com_addr   (mem_waddr),
    .com_lanes  (mem_wbe)
  );

  zt_sram_bank #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) u_bank (
    .clk      (clk),
    .wr_en    (mem_we),
    .wr_lanes (mem_wbe),
    .wr_addr  (mem_waddr),
    .wr_data  (din),
    .rd_addr  (addr),
    .rd_data  (arr_q)
  );

  zt_sram_rdp #(
    .ADDR_W    (ADDR_W),
    .LANE_W    (LANE_W),
    .LANES     (LANES),
    .PIPELINED (PIPELINED)
  ) u_rdp (
    .clk       (clk),
    .rst       (rst),
    .rd_go     (op == OP_READ),
    .rd_addr   (addr),
    .com_vld   (mem_we),
    .com_addr  (mem_waddr),
    .com_lanes (mem_wbe),
    .com_data  (din),
    .arr_q     (arr_q),
    .dout      (dout),
    .dvalid    (dvalid)
  );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int ADDR_W    = 8,
  parameter int LANES     = 4,
  parameter bit PIPELINED = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              ce,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [LANES-1:0]  ben,
  input logic              dvalid,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic [LANES-1:0]  mem_wbe
);
  // Shadow of what was issued one and two edges ago.
  logic              rd_h0, rd_h1, wr_h0, wr_h1, off_h0, off_h1;
  logic [ADDR_W-1:0] a_h0, a_h1;
  logic [LANES-1:0]  b_h0, b_h1;

  always_ff @(posedge clk) begin
    a_h0 <= addr; a_h1 <= a_h0;
    b_h0 <= ben;  b_h1 <= b_h0;
    if (rst) begin
      rd_h0 <= 1'b0; rd_h1 <= 1'b0;
      wr_h0 <= 1'b0; wr_h1 <= 1'b0;
      off_h0 <= 1'b0; off_h1 <= 1'b0;
    end else begin
      rd_h0 <= ce && !we; rd_h1 <= rd_h0;
      wr_h0 <= ce && we;  wr_h1 <= wr_h0;
      off_h0 <= !ce;      off_h1 <= off_h0;
    end
  end

  logic              rd_due, wr_due, off_due;
  logic [ADDR_W-1:0] a_due;
  logic [LANES-1:0]  b_due;
  assign rd_due  = PIPELINED ? rd_h1  : rd_h0;
  assign wr_due  = PIPELINED ? wr_h1  : wr_h0;
  assign off_due = PIPELINED ? off_h1 : off_h0;
  assign a_due   = PIPELINED ? a_h1   : a_h0;
  assign b_due   = PIPELINED ? b_h1   : b_h0;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!dvalid && !mem_we));

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (rst) dvalid == rd_due);

  // R3
  commit_time_chk: assert property (@(posedge clk) disable iff (rst) mem_we == wr_due);

  // R3
  commit_target_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_waddr == a_due && mem_wbe == b_due));

  // R8
  deselect_idle_chk: assert property (@(posedge clk) disable iff (rst)
    off_due |-> (!dvalid && !mem_we));

endmodule

bind zt_sram zt_sram_chk #(
  .ADDR_W    (ADDR_W),
  .LANES     (LANES),
  .PIPELINED (PIPELINED)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce        (ce),
  .we        (we),
  .addr      (addr),
  .ben       (ben),
  .dvalid    (dvalid),
  .mem_we    (mem_we),
  .mem_waddr (mem_waddr),
  .mem_wbe   (mem_wbe)
);

// File: tb/zt_sram_tb.sv
module zt_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 8;
  localparam int DW   = 32;
  localparam int LW   = 8;
  localparam int NL   = DW / LW;
  localparam bit PIPE = 1'b1;
  localparam int LAT  = PIPE ? 2 : 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          ce, we;
  logic [AW-1:0] addr;
  logic [NL-1:0] ben;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dvalid;

  zt_sram #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(PIPE)) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .we(we), .addr(addr), .ben(ben),
    .din(din), .dout(dout), .dvalid(dvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  typedef struct {
    int          due;
    logic [DW-1:0] exp;
    string       tag;
  } item_t;

  item_t         sb[$];
  item_t         mon_it;
  logic [DW-1:0] model [1<<AW];
  logic          hv1 = 1'b0, hv2 = 1'b0;
  logic [DW-1:0] hd1 = '0, hd2 = '0;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  task automatic report();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Driver: presents one access per cycle and feeds the model/scoreboard.
  task automatic step(input logic c, input logic w, input logic [AW-1:0] a,
                      input logic [NL-1:0] b, input logic [DW-1:0] d, input string tag);
    item_t it;
    @(negedge clk);
    ce = c; we = w; addr = a; ben = b;
    if (LAT == 1 ? hv1 : hv2) din = (LAT == 1) ? hd1 : hd2;
    else                      din = $urandom();   // R10: garbage off data cycles
    hv2 = hv1; hd2 = hd1;
    hv1 = c && w; hd1 = d;
    if (c && w) begin
      for (int l = 0; l < NL; l++)
        if (b[l]) model[a][l*LW +: LW] = d[l*LW +: LW];
    end else if (c) begin
      it.due = cyc + LAT;
      it.exp = model[a];
      it.tag = tag;
      sb.push_back(it);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] b,
                    input logic [DW-1:0] d, input string tag);
    step(1'b1, 1'b1, a, b, d, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1'b1, 1'b0, a, '0, '0, tag);
  endtask

  task automatic idle(input logic [AW-1:0] a, input string tag);
    step(1'b0, 1'($urandom()), a, NL'($urandom()), $urandom(), tag);
  endtask

  // Monitor: pops expected reads exactly when they fall due.
  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      if (dvalid) begin
        n_chk++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R8: unexpected dvalid, actual 1 expected 0 at cycle %0d", cyc);
        end else begin
          mon_it = sb.pop_front();
          if (mon_it.due != cyc || dout !== mon_it.exp) begin
            n_fail++;
            $display("FAIL %s (R2): actual cycle %0d data %h, expected cycle %0d data %h",
                     mon_it.tag, cyc, dout, mon_it.due, mon_it.exp);
          end
        end
      end else if (sb.size() > 0 && sb[0].due == cyc) begin
        n_chk++;
        n_fail++;
        mon_it = sb.pop_front();
        $display("FAIL %s (R2): actual dvalid 0, expected 1 with data %h at cycle %0d",
                 mon_it.tag, mon_it.exp, cyc);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4: watchdog, actual no completion expected completion");
      report();
    end
  end

  initial begin
    rst = 1'b1; ce = 1'b0; we = 1'b0; addr = '0; ben = '0; din = '0;
    repeat (4) @(negedge clk);
    // R1: output quiet under reset
    n_chk++;
    if (dvalid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: dvalid actual %b expected 0", dvalid);
    end
    @(negedge clk) rst = 1'b0;

    // R3: back-to-back full writes fill 16 words
    for (int i = 0; i < 16; i++) wr(AW'(i), '1, 32'hA500_0000 + i * 32'h0101_0101, "R3");
    // R2: back-to-back reads of committed words
    for (int i = 0; i < 16; i++) rd(AW'(i), "R2");

    // R4: strict alternation write/read on different addresses
    for (int i = 0; i < 8; i++) begin
      wr(AW'(i), '1, $urandom(), "R4");
      rd(AW'(15 - i), "R4");
    end

    // R5: read right behind write, one gap, two gaps
    wr(8'd3, '1, 32'hDEAD_0003, "R5"); rd(8'd3, "R5");
    wr(8'd4, '1, 32'hDEAD_0004, "R5"); rd(8'd9, "R5"); rd(8'd4, "R5");
    wr(8'd5, '1, 32'hDEAD_0005, "R5"); idle(8'd5, "R5"); idle(8'd5, "R5"); rd(8'd5, "R5");

    // R6: two pending writes to one address, younger wins
    wr(8'd6, '1, 32'h1111_1111, "R6"); wr(8'd6, '1, 32'h2222_2222, "R6"); rd(8'd6, "R6");

    // R7: partial younger write over full older write, both pending
    wr(8'd7, '1, 32'h7777_7777, "R7"); wr(8'd7, 4'b0011, 32'hCCCC_CCCC, "R7"); rd(8'd7, "R7");
    wr(8'd8, 4'b1000, 32'hBB00_0000, "R7"); rd(8'd8, "R7");

    // R9: partial write after commit leaves other lanes
    wr(8'd10, '1, 32'h0A0A_0A0A, "R9");
    wr(8'd10, 4'b0101, 32'hFFFF_FFFF, "R9");
    idle(8'd0, "R9"); idle(8'd0, "R9"); idle(8'd0, "R9");
    rd(8'd10, "R9");

    // R8: deselect cycles with write strobe must not write or output
    wr(8'd11, '1, 32'h5555_AAAA, "R8");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 8'd11, '1, 32'h0BAD_0BAD, "R8");
    rd(8'd11, "R8");

    // R10: idle and read cycles with junk on din leave word intact
    wr(8'd12, '1, 32'h1234_5678, "R10");
    for (int i = 0; i < 4; i++) rd(8'd13, "R10");
    idle(8'd12, "R10");
    rd(8'd12, "R10");

    // R4: random mix of all access kinds
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom() % 100);
      if (r < 15)      idle(AW'($urandom() % 16), "R4");
      else if (r < 55) wr(AW'($urandom() % 16), NL'($urandom()), $urandom(), "R4");
      else             rd(AW'($urandom() % 16), "R4");
    end

    for (int i = 0; i < LAT + 3; i++) idle(8'd0, "R2");
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R2: outstanding reads actual %0d expected 0", sb.size());
    end
    report();
  end

endmodule